// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block divides a fast input clock by an average ratio of N + F, where N is an unsigned integer and F is a fraction. Each output period lasts either N or N+1 input cycles. A fractional accumulator decides which. Once per output period the accumulator adds F to its running sum. When the sum reaches or passes one, it raises a carry and keeps only the fractional part. That carry sets the length of the following period. Over many periods the long lengths occur in a proportion F, so the mean ratio is N + F. For example, N = 10 with F ≈ 0.3 averages about 10.3.

The division itself is done by a swallow-counter arrangement:
- A dual-modulus prescaler divides by P or P+1.
- A main counter counts prescaler cycles.
- A swallow counter keeps the prescaler in its P+1 mode for the first S of those cycles.

Together they give a period of M·P + S input cycles. The block exports two things to a downstream phase-error compensator: the accumulator residue, and the modulus select of the current period. The divider, the integer ratio and the fraction are plain control and status pins. There is no stream traffic, so there is no valid/ready handshake.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While `rst_i` is high (synchronous reset), `div_pulse_o` is 0, `mod_sel_o` is 0 and `residue_o` is 0. The first output period after reset lasts exactly N input cycles.
- R2: Every output period lasts N + c input cycles, where c is the value of `mod_sel_o` during the pulse that opened the period (0 selects N, 1 selects N+1).
- R3: At each period boundary the residue becomes (residue + F) mod 2^FW. `mod_sel_o` becomes the overflow bit of that sum. F is `ratio_frac_i`, read as an unsigned numerator over 2^FW.
- R4: Starting from reset with constant N and F, exactly F of the first 2^FW period boundaries set `mod_sel_o` to 1, and the residue is 0 again after the last of them.
- R5: With F = 0, `mod_sel_o` never goes high and every period lasts N cycles.
- R6: `div_pulse_o` is high for exactly one input cycle per output period.
- R7: `ratio_int_i` and `ratio_frac_i` are sampled only at the clock edge that ends a period. Changing them partway through a period leaves that period's length unchanged.
- R8: An integer ratio below NMIN = P·(P−1) is treated as NMIN (2 with default parameters, P = 2^PRE_LOG2).
- R9: The maximum integer ratio 2^NW − 1 with a carry of 1 yields a period of 2^NW cycles, with no truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_int_i | input | NW | Integer part N of the division ratio |
| ratio_frac_i | input | FW | Fractional part F as a numerator over 2^FW |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each divided period |
| mod_sel_o | output | 1 | Modulus select (accumulator carry): 1 means the current period lasts N+1 |
| residue_o | output | FW | Accumulator residue, for phase-error compensation |

## Verification
The bench measures every period between pulses and replays the accumulator in its own model. Several corner cases are targeted:
- **Fraction of zero.** A design that raised a stray carry here would stretch periods.
- **Fraction of 2^FW − 1 with the largest N.** A design that truncated N+1 would produce a period of 0 or 1 cycles instead of 2^NW.
- **N below the swallow limit.** Without the clamp, the swallow count would exceed the main count and the period length would be wrong.
- **Ratio and fraction changed mid-period.** A design that sampled them continuously would produce periods matching neither the old nor the new ratio.

A full run of 2^FW periods also exposes an off-by-one in the carry comparison, because the count of long periods would then differ from F.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } modsel_e;

  // Smallest total ratio that a P/P+1 swallow divider can form for every
  // swallow count: the main count must never be below the swallow count.
  function automatic int unsigned min_ratio(int unsigned plog2);
    int unsigned p;
    p = 32'd1 << plog2;
    return p * (p - 32'd1);
  endfunction

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_i,
  input  logic [FW-1:0] frac_i,
  output logic          carry_nxt_o,
  output logic          carry_o,
  output logic [FW-1:0] resid_o
);

  logic [FW:0]   sum;
  logic [FW-1:0] resid_q;
  modsel_e       carry_q;

  assign sum         = {1'b0, resid_q} + {1'b0, frac_i};
  assign carry_nxt_o = sum[FW];
  assign carry_o     = carry_q;
  assign resid_o     = resid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      resid_q <= '0;
      carry_q <= MOD_BASE;
    end else if (step_i) begin
      resid_q <= sum[FW-1:0];
      carry_q <= modsel_e'(sum[FW]);
    end
  end

  // R3: an overflow step always lowers the residue
  p_wrap_lowers_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(step_i) && !$past(rst_i) && carry_q == MOD_PLUS) |-> (resid_q < $past(resid_q)));

  // R3: a step without overflow never lowers the residue
  p_nowrap_keeps_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(step_i) && !$past(rst_i) && carry_q == MOD_BASE) |-> (resid_q >= $past(resid_q)));

  // R7: state moves only on a period boundary
  p_hold_between_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(step_i) && !$past(rst_i)) |-> ($stable(resid_q) && $stable(carry_q)));

endmodule

// File: rtl/fracn_prescaler.sv
module fracn_prescaler #(
  parameter int PRE_LOG2 = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic plus_i,
  output logic tick_o
);

  localparam int P  = 1 << PRE_LOG2;
  localparam int CW = PRE_LOG2 + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = plus_i ? CW'(P) : CW'(P - 1);
  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: prescaler ticks are never adjacent (modulus is at least 2)
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  // R2: modulus select stays put inside one prescaler cycle
  p_mod_steady_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(tick_o) && !$past(rst_i)) |-> $stable(plus_i));

  // R2: counter never passes the long modulus
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CW'(P));

endmodule

// File: rtl/fracn_swallow.sv
module fracn_swallow #(
  parameter int DW       = 9,
  parameter int PRE_LOG2 = 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          plus_o,
  output logic          term_o
);

  localparam int MW = DW - PRE_LOG2;

  logic [MW-1:0]       m_lat, mcnt_q;
  logic [PRE_LOG2-1:0] s_lat, scnt_q;

  assign plus_o = (scnt_q < s_lat);
  assign term_o = tick_i && (mcnt_q == m_lat - 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i || term_o) begin
      m_lat  <= load_val_i[DW-1:PRE_LOG2];
      s_lat  <= load_val_i[PRE_LOG2-1:0];
      mcnt_q <= '0;
      scnt_q <= '0;
    end else if (tick_i) begin
      mcnt_q <= mcnt_q + 1'b1;
      if (plus_o) scnt_q <= scnt_q + 1'b1;
    end
  end

  // R8: the loaded ratio always leaves room for every swallowed cycle
  p_swallow_fits_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (MW'(s_lat) <= m_lat) && (m_lat != '0));

  // R2: swallow count never overshoots its target
  p_scnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    scnt_q <= s_lat);

  // R6: period ends are never adjacent
  p_term_gap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    term_o |=> !term_o);

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int NW       = 8,
  parameter int FW       = 8,
  parameter int PRE_LOG2 = 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NW-1:0] ratio_int_i,
  input  logic [FW-1:0] ratio_frac_i,
  output logic          div_pulse_o,
  output logic          mod_sel_o,
  output logic [FW-1:0] residue_o
);

  localparam int DW   = NW + 1;
  localparam int NMIN = int'(min_ratio(PRE_LOG2));

  logic [NW-1:0] n_eff;
  logic [DW-1:0] load_val;
  logic          carry_nxt, tick, plus, term;
  logic          pulse_q;

  assign n_eff    = (ratio_int_i < NW'(NMIN)) ? NW'(NMIN) : ratio_int_i;
  assign load_val = {1'b0, n_eff} + DW'(rst_i ? 1'b0 : carry_nxt);

  fracn_accum #(.FW(FW)) u_accum (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .step_i      (term),
    .frac_i      (ratio_frac_i),
    .carry_nxt_o (carry_nxt),
    .carry_o     (mod_sel_o),
    .resid_o     (residue_o)
  );

  fracn_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .plus_i (plus),
    .tick_o (tick)
  );

  fracn_swallow #(.DW(DW), .PRE_LOG2(PRE_LOG2)) u_swl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_val_i (load_val),
    .tick_i     (tick),
    .plus_o     (plus),
    .term_o     (term)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) pulse_q <= 1'b0;
    else       pulse_q <= term;
  end
  assign div_pulse_o = pulse_q;

  // R7: the modulus select changes only together with the output pulse
  p_mod_at_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!div_pulse_o && !$past(rst_i)) |-> $stable(mod_sel_o));

  // R6: one-cycle pulse
  p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    div_pulse_o |=> !div_pulse_o);

endmodule

// File: tb/tb_fracn_div_ctrl.sv
module tb_fracn_div_ctrl;
  localparam int NW = 8, FW = 8, PL = 1, NMIN = 2;
  localparam int WDOG = 190000;

  logic          clk = 1'b0, rst = 1'b1;
  logic [NW-1:0] n_in = 8'd10;
  logic [FW-1:0] f_in = 8'd77;
  logic          div_pulse, mod_sel;
  logic [FW-1:0] residue;

  int errors = 0, checks = 0, total_cyc = 0;
  int m_acc, exp_len, cyc;

  fracn_div_ctrl #(.NW(NW), .FW(FW), .PRE_LOG2(PL)) dut (
    .clk_i(clk), .rst_i(rst), .ratio_int_i(n_in), .ratio_frac_i(f_in),
    .div_pulse_o(div_pulse), .mod_sel_o(mod_sel), .residue_o(residue));

  always #10 clk = ~clk;

  function automatic int eff_n(int n);
    return (n < NMIN) ? NMIN : n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > WDOG) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", total_cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
    check(mod_sel == 1'b0, "R1 modsel in reset", int'(mod_sel), 0);
    check(residue == '0, "R1 residue in reset", int'(residue), 0);
    rst = 1'b0;
    m_acc = 0; cyc = 0;
    exp_len = eff_n(int'(n_in));
  endtask

  task automatic run(int periods, int chg_pct, string tag, output int ncarry);
    int seen = 0;
    int s, c;
    ncarry = 0;
    while (seen < periods) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(div_pulse == 1'b0, "R6 single-cycle pulse", int'(div_pulse), 0);
      if (div_pulse) begin
        check(cyc == exp_len, (seen == 0) ? "R1 first period" : tag, cyc, exp_len);
        s = m_acc + int'(f_in);
        c = s >> FW;
        m_acc = s % (1 << FW);
        check(int'(mod_sel) == c, "R3 carry", int'(mod_sel), c);
        check(int'(residue) == m_acc, "R3 residue", int'(residue), m_acc);
        exp_len = eff_n(int'(n_in)) + c;
        cyc = 0;
        seen++;
        ncarry += c;
      end
      if (chg_pct > 0 && $urandom_range(99) < chg_pct) begin
        n_in = NW'($urandom_range(60));
        f_in = FW'($urandom);
      end
    end
  endtask

  initial begin
    int nc;
    int unsigned seed_init;
    seed_init = $urandom(32'hC0FFEE);

    // N=10, F=77/256 (about 0.3): full accumulator cycle
    n_in = 8'd10; f_in = 8'd77;
    do_reset();
    run(1 << FW, 0, "R2 period length", nc);
    check(nc == 77, "R4 long-period count", nc, 77);
    check(residue == '0, "R4 residue returns to zero", int'(residue), 0);

    // F = 0: never a long period
    n_in = 8'd5; f_in = 8'd0;
    do_reset();
    run(40, 0, "R5 period length", nc);
    check(nc == 0, "R5 no carry", nc, 0);
    check(mod_sel == 1'b0, "R5 modsel low", int'(mod_sel), 0);

    // Largest N with nearly full fraction
    n_in = 8'd255; f_in = 8'd255;
    do_reset();
    run(1 << FW, 0, "R2 R9 period length", nc);
    check(nc == 255, "R4 R9 long-period count", nc, 255);

    // N below the swallow minimum
    n_in = 8'd0; f_in = 8'd128;
    do_reset();
    run(20, 0, "R2 R8 clamped period", nc);
    n_in = 8'd1; f_in = 8'd200;
    do_reset();
    run(20, 0, "R2 R8 clamped period", nc);

    // Random ratios with mid-period changes
    for (int seg = 0; seg < 20; seg++) begin
      n_in = NW'($urandom_range(60));
      f_in = FW'($urandom);
      do_reset();
      run(30, 5, "R2 R7 period after change", nc);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule